// File: doc/BRIEF.md
# Counter Channel Flag Event Generator

One channel of an up/down position counter whose single interrupt-request pulse can come from one of four sources. A decoder outside this block supplies count-up and count-down strobes. The channel keeps a 25-bit count and a 24-bit preset. It drives two active-low flags, one for wrap-around upward and one for wrap-around downward, and it emits a one-cycle event pulse.

Configuration comes from a control byte written over a simple register port. Bit 0 enables counting. Bit 1 lets a rising index edge load the preset into the count. Bits 4:3 select the event source: 0 for upward wrap, 1 for count-equals-preset, 2 for a wrap in either direction, and 3 for a rising index edge. A host normally writes the preset, selects a source, and then waits for pulses on the event output.

Top module: `cfc_chan`

## Requirements
- R1: After reset the count is 0, both wrap flags (`carry_n`, `borrow_n`) are 1, `event_o` is 0, and the control byte is 0, which means counting is disabled and the source is upward wrap.
- R2: While control bit 0 is 1, the count changes on a clock edge as follows: `up_stb` alone adds 1, `dn_stb` alone subtracts 1, and both or neither leave it unchanged. While bit 0 is 0 the strobes are ignored.
- R3: Adding 1 to 2^25-1 gives 0 and toggles `carry_n`. Subtracting 1 from 0 gives 2^25-1 and toggles `borrow_n`. Neither flag changes at any other time.
- R4: `cnt_wr` loads `ld_data` (24 bits) into the count and clears bit 24. `pre_wr` stores `ld_data` as the preset.
- R5: While control bit 1 is 1, a rising edge of `index_in` loads the preset into the count, with bit 24 cleared. While bit 1 is 0 the index does not touch the count.
- R6: Source 0 raises an event on the edge where the count wraps upward, and never on a downward wrap.
- R7: Source 1 raises an event on the edge where the count becomes equal to the zero-extended preset. A match that persists does not raise another event.
- R8: Source 2 raises an event on every wrap, upward or downward.
- R9: Source 3 raises an event on the edge that samples a rising `index_in`. An index held high does not raise another event.
- R10: Each event is a pulse one cycle long.
- R11: A control write takes effect from the following clock. The edge that performs the write emits no event. A condition that already holds under the new source, such as a match that persists, does not raise an event.
- R12: On a single edge, `cnt_wr` has priority over an index preset load, and an index preset load has priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_stb | input | 1 | Decoded count-up strobe |
| dn_stb | input | 1 | Decoded count-down strobe |
| index_in | input | 1 | Active-high index input |
| ld_data | input | 24 | Data for count or preset writes |
| cnt_wr | input | 1 | Load `ld_data` into the count |
| pre_wr | input | 1 | Store `ld_data` as the preset |
| ctl_wr | input | 1 | Write the control byte |
| ctl_data | input | 8 | Control byte: bit 0 enable, bit 1 index load, bits 4:3 source |
| count_o | output | 25 | Current count |
| carry_n | output | 1 | Upward-wrap toggle flag, active low |
| borrow_n | output | 1 | Downward-wrap toggle flag, active low |
| event_o | output | 1 | One-cycle event pulse |

## Verification
A table of up, down, both-strobe and idle steps runs in compare mode. It separates a new match from a match that persists, and it checks that holding on simultaneous strobes does not retrigger. Directed sequences run each source through both wrap directions. They show that upward-wrap mode ignores a downward wrap, while either-wrap mode reacts to both directions on consecutive edges. Further sequences place a load, an index edge and a strobe on the same edge to check the load priority. Other sequences switch the source while a condition already holds, to check that no event is carried across a control write.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
   typedef enum logic [1:0] {
      FN_CARRY = 2'd0,
      FN_MATCH = 2'd1,
      FN_WRAP  = 2'd2,
      FN_INDEX = 2'd3
   } flag_fn_e;

   localparam int CTL_W       = 8;
   localparam int EN_BIT      = 0;
   localparam int IDXLD_BIT   = 1;
   localparam int FN_LSB      = 3;
   localparam int FN_W        = 2;
endpackage

// File: rtl/cfc_ctl_reg.sv
module cfc_ctl_reg
   import cfc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_data,
   output logic             cnt_en,
   output logic             idx_ld_en,
   output flag_fn_e         fn_sel
);
   logic unused_ctl_bits;
   assign unused_ctl_bits = ^{ctl_data[CTL_W-1:FN_LSB+FN_W], ctl_data[FN_LSB-1:IDXLD_BIT+1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_en    <= 1'b0;
         idx_ld_en <= 1'b0;
         fn_sel    <= FN_CARRY;
      end else if (ctl_wr) begin
         cnt_en    <= ctl_data[EN_BIT];
         idx_ld_en <= ctl_data[IDXLD_BIT];
         fn_sel    <= flag_fn_e'(ctl_data[FN_LSB +: FN_W]);
      end
   end
endmodule

// File: rtl/cfc_counter.sv
module cfc_counter #(
   parameter int CNT_W  = 25,
   parameter int LOAD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              up_stb,
   input  logic              dn_stb,
   input  logic              cnt_wr,
   input  logic              pre_wr,
   input  logic              idx_load,
   input  logic [LOAD_W-1:0] ld_data,
   output logic [CNT_W-1:0]  count_q,
   output logic              carry_n,
   output logic              borrow_n,
   output logic              ovf_hit,
   output logic              unf_hit,
   output logic              match_next
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam int PAD_W = CNT_W - LOAD_W;

   logic [LOAD_W-1:0] preset_q, preset_d;
   logic [CNT_W-1:0]  count_d;
   logic              inc, dec, any_load;

   assign inc      = cnt_en & up_stb & ~dn_stb;
   assign dec      = cnt_en & dn_stb & ~up_stb;
   assign any_load = cnt_wr | idx_load;
   assign ovf_hit  = inc & ~any_load & (count_q == CNT_MAX);
   assign unf_hit  = dec & ~any_load & (count_q == '0);
   assign preset_d = pre_wr ? ld_data : preset_q;

   always_comb begin
      if (cnt_wr)        count_d = {{PAD_W{1'b0}}, ld_data};
      else if (idx_load) count_d = {{PAD_W{1'b0}}, preset_q};
      else if (inc)      count_d = count_q + CNT_W'(1);
      else if (dec)      count_d = count_q - CNT_W'(1);
      else               count_d = count_q;
   end

   assign match_next = (count_d == {{PAD_W{1'b0}}, preset_d});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= '0;
         preset_q <= '0;
         carry_n  <= 1'b1;
         borrow_n <= 1'b1;
      end else begin
         count_q  <= count_d;
         preset_q <= preset_d;
         if (ovf_hit) carry_n  <= ~carry_n;
         if (unf_hit) borrow_n <= ~borrow_n;
      end
   end

   assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !cnt_wr && !idx_load) |=> $stable(count_q));
   assert_carry_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_hit |=> (carry_n != $past(carry_n)) && (count_q == '0));
   assert_carry_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf_hit |=> $stable(carry_n));
   assert_borrow_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      unf_hit |=> (borrow_n != $past(borrow_n)) && (count_q == CNT_MAX));
   assert_load_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (count_q[CNT_W-1:LOAD_W] == '0) && (count_q[LOAD_W-1:0] == $past(ld_data)));
endmodule

// File: rtl/cfc_event_sel.sv
module cfc_event_sel
   import cfc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  flag_fn_e fn_sel,
   input  logic     ctl_wr,
   input  logic     ovf_hit,
   input  logic     unf_hit,
   input  logic     match_next,
   input  logic     idx_rise,
   output logic     event_o
);
   logic match_q, raw;

   always_comb begin
      unique case (fn_sel)
         FN_CARRY: raw = ovf_hit;
         FN_MATCH: raw = match_next & ~match_q;
         FN_WRAP:  raw = ovf_hit | unf_hit;
         FN_INDEX: raw = idx_rise;
         default:  raw = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         event_o <= 1'b0;
      end else begin
         match_q <= match_next;
         event_o <= raw & ~ctl_wr;
      end
   end

   assert_quiet_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> !event_o);
   assert_index_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_sel == FN_INDEX && !ctl_wr && idx_rise) |=> event_o);
   assert_no_down_in_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_sel == FN_CARRY && unf_hit) |=> !event_o);
endmodule

// File: rtl/cfc_chan.sv
module cfc_chan
   import cfc_pkg::*;
#(
   parameter int CNT_W  = 25,
   parameter int LOAD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_stb,
   input  logic              dn_stb,
   input  logic              index_in,
   input  logic [LOAD_W-1:0] ld_data,
   input  logic              cnt_wr,
   input  logic              pre_wr,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_data,
   output logic [CNT_W-1:0]  count_o,
   output logic              carry_n,
   output logic              borrow_n,
   output logic              event_o
);
   generate
      if (LOAD_W < 1 || LOAD_W >= CNT_W) begin : g_bad_width
         $error("cfc_chan: LOAD_W must be at least 1 and below CNT_W");
      end
      if (FN_LSB + FN_W > CTL_W) begin : g_bad_ctl
         $error("cfc_chan: source field does not fit the control byte");
      end
   endgenerate

   logic     cnt_en, idx_ld_en, idx_q, idx_rise, idx_load;
   logic     ovf_hit, unf_hit, match_next;
   flag_fn_e fn_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) idx_q <= 1'b0;
      else        idx_q <= index_in;
   end

   assign idx_rise = index_in & ~idx_q;
   assign idx_load = idx_rise & idx_ld_en;

   cfc_ctl_reg u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_data  (ctl_data),
      .cnt_en    (cnt_en),
      .idx_ld_en (idx_ld_en),
      .fn_sel    (fn_sel)
   );

   cfc_counter #(.CNT_W(CNT_W), .LOAD_W(LOAD_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_en     (cnt_en),
      .up_stb     (up_stb),
      .dn_stb     (dn_stb),
      .cnt_wr     (cnt_wr),
      .pre_wr     (pre_wr),
      .idx_load   (idx_load),
      .ld_data    (ld_data),
      .count_q    (count_o),
      .carry_n    (carry_n),
      .borrow_n   (borrow_n),
      .ovf_hit    (ovf_hit),
      .unf_hit    (unf_hit),
      .match_next (match_next)
   );

   cfc_event_sel u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .fn_sel     (fn_sel),
      .ctl_wr     (ctl_wr),
      .ovf_hit    (ovf_hit),
      .unf_hit    (unf_hit),
      .match_next (match_next),
      .idx_rise   (idx_rise),
      .event_o    (event_o)
   );

   assert_index_priority_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_load && !cnt_wr) |=> (count_o[CNT_W-1:LOAD_W] == '0));
endmodule

// File: tb/cfc_chan_tb.sv
module cfc_chan_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [24:0] MAXC = 25'h1FFFFFF;
   // vector: [10] up, [9] dn, [8] expected event, [7:0] expected count
   localparam logic [10:0] VEC [0:7] = '{
      {1'b1, 1'b0, 1'b0, 8'd1},
      {1'b1, 1'b0, 1'b0, 8'd2},
      {1'b1, 1'b0, 1'b1, 8'd3},
      {1'b1, 1'b1, 1'b0, 8'd3},
      {1'b0, 1'b0, 1'b0, 8'd3},
      {1'b0, 1'b1, 1'b0, 8'd2},
      {1'b1, 1'b0, 1'b1, 8'd3},
      {1'b1, 1'b0, 1'b0, 8'd4}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        up_stb = 0, dn_stb = 0, index_in = 0, cnt_wr = 0, pre_wr = 0, ctl_wr = 0;
   logic [23:0] ld_data = '0;
   logic [7:0]  ctl_data = '0;
   logic [24:0] count_o;
   logic        carry_n, borrow_n, event_o;
   int          checks = 0, errors = 0;
   bit          done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfc_chan u_dut (
      .clk(clk), .rst_n(rst_n), .up_stb(up_stb), .dn_stb(dn_stb), .index_in(index_in),
      .ld_data(ld_data), .cnt_wr(cnt_wr), .pre_wr(pre_wr), .ctl_wr(ctl_wr),
      .ctl_data(ctl_data), .count_o(count_o), .carry_n(carry_n), .borrow_n(borrow_n),
      .event_o(event_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic up, input logic dn, input logic idx,
                       input logic cw, input logic pw, input logic [23:0] d,
                       input logic kw, input logic [7:0] kd);
      @(negedge clk);
      up_stb = up; dn_stb = dn; index_in = idx; cnt_wr = cw; pre_wr = pw;
      ld_data = d; ctl_wr = kw; ctl_data = kd;
      @(posedge clk);
      #1;
   endtask

   task automatic ctl(input logic [7:0] kd);
      step(0, 0, 0, 0, 0, '0, 1, kd);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 count", 32'(count_o), 0);
      chk("R1 carry_n", 32'(carry_n), 1);
      chk("R1 borrow_n", 32'(borrow_n), 1);
      chk("R1 event", 32'(event_o), 0);
      @(negedge clk); rst_n = 1'b1;
      step(1, 0, 0, 0, 0, '0, 0, 0);
      chk("R1 R2 disabled after reset", 32'(count_o), 0);
      // enable, compare source, preset 3
      step(0, 0, 0, 0, 1, 24'd3, 1, 8'h09);
      for (int i = 0; i < 8; i++) begin
         step(VEC[i][10], VEC[i][9], 0, 0, 0, '0, 0, 0);
         chk("R2 table count", 32'(count_o), 32'(VEC[i][7:0]));
         chk("R7 table event", 32'(event_o), 32'(VEC[i][8]));
      end
      // R5 / R12: index preset load
      ctl(8'h0B);
      chk("R11 write edge quiet", 32'(event_o), 0);
      step(0, 0, 1, 0, 0, '0, 0, 0);
      chk("R5 index load", 32'(count_o), 3);
      chk("R7 match by load", 32'(event_o), 1);
      step(0, 0, 0, 0, 0, '0, 0, 0);
      step(0, 0, 1, 1, 0, 24'h20, 0, 0);
      chk("R12 cnt_wr over index", 32'(count_o), 32'h20);
      step(0, 0, 0, 0, 0, '0, 0, 0);
      step(1, 0, 1, 0, 0, '0, 0, 0);
      chk("R12 index over count", 32'(count_o), 3);
      step(0, 0, 0, 0, 0, '0, 0, 0);
      ctl(8'h09);
      step(0, 0, 0, 1, 0, 24'h20, 0, 0);
      step(0, 0, 1, 0, 0, '0, 0, 0);
      chk("R5 no load when off", 32'(count_o), 32'h20);
      step(0, 0, 0, 0, 0, '0, 0, 0);
      // R2 disabled
      ctl(8'h08);
      step(1, 0, 0, 0, 0, '0, 0, 0);
      chk("R2 up ignored", 32'(count_o), 32'h20);
      step(0, 1, 0, 0, 0, '0, 0, 0);
      chk("R2 down ignored", 32'(count_o), 32'h20);
      // R11 mode switch with standing match
      ctl(8'h01);
      step(0, 0, 0, 1, 0, 24'd3, 0, 0);
      chk("R6 match ignored in carry", 32'(event_o), 0);
      ctl(8'h09);
      chk("R11 switch edge", 32'(event_o), 0);
      step(0, 0, 0, 0, 0, '0, 0, 0);
      chk("R11 standing match not carried", 32'(event_o), 0);
      step(1, 0, 0, 0, 0, '0, 0, 0);
      chk("R7 leave match", 32'(event_o), 0);
      step(0, 1, 0, 0, 0, '0, 0, 0);
      chk("R7 re-match", 32'(event_o), 1);
      // R3 / R6 wraps in carry mode
      ctl(8'h01);
      step(0, 0, 0, 1, 0, 24'd0, 0, 0);
      step(0, 1, 0, 0, 0, '0, 0, 0);
      chk("R3 underflow count", 32'(count_o), 32'(MAXC));
      chk("R3 borrow toggled", 32'(borrow_n), 0);
      chk("R3 carry steady", 32'(carry_n), 1);
      chk("R6 no event on underflow", 32'(event_o), 0);
      step(1, 0, 0, 0, 0, '0, 0, 0);
      chk("R3 overflow count", 32'(count_o), 0);
      chk("R3 carry toggled", 32'(carry_n), 0);
      chk("R6 event on overflow", 32'(event_o), 1);
      step(0, 0, 0, 0, 0, '0, 0, 0);
      chk("R10 pulse ends", 32'(event_o), 0);
      // R8 either wrap
      ctl(8'h11);
      step(0, 1, 0, 0, 0, '0, 0, 0);
      chk("R8 underflow event", 32'(event_o), 1);
      chk("R3 borrow back", 32'(borrow_n), 1);
      step(1, 0, 0, 0, 0, '0, 0, 0);
      chk("R8 overflow event", 32'(event_o), 1);
      chk("R3 carry back", 32'(carry_n), 1);
      step(0, 0, 0, 0, 0, '0, 0, 0);
      chk("R10 pulse ends wrap", 32'(event_o), 0);
      // R9 index source
      ctl(8'h19);
      step(0, 0, 1, 0, 0, '0, 0, 0);
      chk("R9 index rise", 32'(event_o), 1);
      chk("R5 no load in R9", 32'(count_o), 0);
      step(0, 0, 1, 0, 0, '0, 0, 0);
      chk("R9 held index quiet", 32'(event_o), 0);
      step(1, 0, 0, 0, 0, '0, 0, 0);
      chk("R9 count not an event", 32'(event_o), 0);
      // R4 full-width load
      step(0, 0, 0, 1, 0, 24'hFFFFFF, 0, 0);
      chk("R4 top bit cleared", 32'(count_o), 32'h0FFFFFF);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule